// File: doc/BRIEF.md
# Bit-Synchronous HDLC Frame Receiver with Octet Limit

This block receives one bit-synchronous HDLC serial channel. A bit is sampled on each clock where the bit enable is high. The receiver hunts for the flag pattern and removes the zeros that a transmitter inserts after five ones. It packs the remaining bits into octets, least significant bit first, and delivers them as a byte stream marked with start-of-frame and end-of-frame. At the end of each frame, exactly one status pulse reports how the frame ended: good, aborted, too long, or closed on a flag that did not fall on an octet boundary.

A length limit can be enabled. The receiver counts every octet between the opening and closing flags, so the checksum octets are included in the count. As soon as the count would pass the programmed maximum, the frame is closed with a too-long status. The rest of that frame is then dropped until the next flag arrives. Each delivered octet is held back by one octet, so the last octet of a frame is never mistaken for the bits of a closing flag.

Top module: `hdlc_rx_limit`

## Requirements
- R1: While reset is active and right after it, every output is 0. Until the first flag (0x7E) is seen, no byte, frame-end or status is produced.
- R2: The octets between an opening and a closing 0x7E flag are delivered in order on out_data with out_valid. The first octet of each frame is least significant bit first on the line. The first octet carries out_sof. The last octet carries out_eof together with st_good.
- R3: A 0 that follows five consecutive 1s inside a frame is removed from the data. This lets octets such as 0xFF, 0x7E and 0x3F pass through unchanged.
- R4: Flags that follow each other with no octet between them produce no byte, no frame-end and no status.
- R5: Seven or more consecutive 1s abort the current frame. If at least one octet was received, out_eof and st_abort pulse with out_valid low, and the held octet is dropped. Nothing more is produced until the next flag. An abort before any octet produces nothing.
- R6: With len_chk_en at 1, the frame is closed as soon as its octet count would exceed max_len. The first max_len octets are delivered, and the last of them carries out_eof and st_too_long. The rest of the frame is discarded up to the next flag. When max_len is 0, out_eof and st_too_long pulse with out_valid low.
- R7: With len_chk_en at 0, frames of any length are delivered in full, whatever max_len holds.
- R8: A frame whose octet count equals max_len is delivered as a good frame.
- R9: If the bits between the flags do not form a whole number of octets, the closing flag ends the frame with out_eof and st_misalign, and out_valid is low.
- R10: Line bits are taken only in cycles with bit_en high. Every output is a single-cycle pulse that follows a cycle with bit_en high.
- R11: Each out_eof carries exactly one of st_good, st_abort, st_too_long and st_misalign, and none of these is ever high without out_eof.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Line bit valid in this cycle |
| bit_in | input | 1 | Serial line bit |
| len_chk_en | input | 1 | Enables the octet length limit (static) |
| max_len | input | LEN_W | Largest permitted octet count per frame (static) |
| out_valid | output | 1 | out_data holds a received octet |
| out_data | output | 8 | Received octet |
| out_sof | output | 1 | Octet is the first of its frame |
| out_eof | output | 1 | Frame ends in this cycle |
| st_good | output | 1 | Frame ended correctly |
| st_abort | output | 1 | Frame ended by an abort sequence |
| st_too_long | output | 1 | Frame cut at the length limit |
| st_misalign | output | 1 | Closing flag not on an octet boundary |

## Verification
The properties assume that len_chk_en and max_len stay fixed while the block is out of reset. The length-bound property compares the live octet counter with a max_len that must not move under it. The stimulus therefore changes the configuration only while reset is held, and the limit sweep resets once per value of max_len. Idle cycles with bit_en low carry the inverted bit on the line, which shows that the receiver ignores the line between enables.

// File: rtl/hdlc_rx_limit.sv
module hdlc_rx_limit #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             bit_in,
  input  logic             len_chk_en,
  input  logic [LEN_W-1:0] max_len,
  output logic             out_valid,
  output logic [7:0]       out_data,
  output logic             out_sof,
  output logic             out_eof,
  output logic             st_good,
  output logic             st_abort,
  output logic             st_too_long,
  output logic             st_misalign
);

  localparam int CW = LEN_W + 1;
  localparam logic [CW-1:0] CNT_TOP = {1'b1, {LEN_W{1'b0}}};

  logic [2:0]    ones;
  logic [2:0]    bcnt;
  logic [7:0]    sh;
  logic [7:0]    pend;
  logic [CW-1:0] cnt;
  logic          in_frame;

  wire           flag_ev   = bit_en && !bit_in && ones == 3'd6;
  wire           abort_ev  = bit_en &&  bit_in && ones == 3'd6;
  wire           data_ev   = bit_en && in_frame && ones < 3'd5;
  wire           byte_done = bcnt == 3'd7;
  wire [7:0]     new_byte  = {bit_in, sh[7:1]};
  wire           has_oct   = cnt != '0;
  wire           first_oct = cnt == CW'(1);
  wire [CW-1:0]  cnt_inc   = (cnt == CNT_TOP) ? cnt : cnt + CW'(1);
  wire           over      = len_chk_en && (cnt_inc > {1'b0, max_len});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ones        <= '0;
      bcnt        <= '0;
      sh          <= '0;
      pend        <= '0;
      cnt         <= '0;
      in_frame    <= 1'b0;
      out_valid   <= 1'b0;
      out_data    <= '0;
      out_sof     <= 1'b0;
      out_eof     <= 1'b0;
      st_good     <= 1'b0;
      st_abort    <= 1'b0;
      st_too_long <= 1'b0;
      st_misalign <= 1'b0;
    end else begin
      out_valid   <= 1'b0;
      out_sof     <= 1'b0;
      out_eof     <= 1'b0;
      st_good     <= 1'b0;
      st_abort    <= 1'b0;
      st_too_long <= 1'b0;
      st_misalign <= 1'b0;
      if (bit_en)
        ones <= bit_in ? ((ones == 3'd7) ? ones : ones + 3'd1) : 3'd0;
      if (flag_ev) begin
        if (in_frame && has_oct) begin
          out_eof <= 1'b1;
          if (bcnt == 3'd6) begin
            out_valid <= 1'b1;
            out_data  <= pend;
            out_sof   <= first_oct;
            st_good   <= 1'b1;
          end else begin
            st_misalign <= 1'b1;
          end
        end
        in_frame <= 1'b1;
        cnt      <= '0;
        bcnt     <= '0;
      end else if (abort_ev) begin
        if (in_frame && has_oct) begin
          out_eof  <= 1'b1;
          st_abort <= 1'b1;
        end
        in_frame <= 1'b0;
      end else if (data_ev) begin
        sh   <= new_byte;
        bcnt <= bcnt + 3'd1;
        if (byte_done) begin
          if (has_oct) begin
            out_valid <= 1'b1;
            out_data  <= pend;
            out_sof   <= first_oct;
          end
          if (over) begin
            out_eof     <= 1'b1;
            st_too_long <= 1'b1;
            in_frame    <= 1'b0;
          end else begin
            pend <= new_byte;
            cnt  <= cnt_inc;
          end
        end
      end
    end
  end

  AST_EOF_ONE_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    out_eof |-> $countones({st_good, st_abort, st_too_long, st_misalign}) == 1); // R11
  AST_STATUS_WITH_EOF: assert property (@(posedge clk) disable iff (!rst_n)
    (st_good || st_abort || st_too_long || st_misalign) |-> out_eof); // R11
  AST_GOOD_CARRIES_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    st_good |-> out_valid); // R2
  AST_SOF_CARRIES_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    out_sof |-> out_valid); // R2
  AST_ERR_NO_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_abort || st_misalign) |-> !out_valid); // R5
  AST_OUT_AFTER_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid || out_eof) |-> $past(bit_en)); // R10
  AST_EOF_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    out_eof |=> !out_eof); // R10
  AST_LIMIT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (in_frame && len_chk_en) |-> cnt <= {1'b0, max_len}); // R6
  AST_NO_CUT_UNCHECKED: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(len_chk_en) |-> !st_too_long); // R7

endmodule

// File: tb/test_hdlc_rx_limit.sv
`timescale 1ns/1ps
module test_hdlc_rx_limit;
  localparam logic [7:0] FLAG = 8'h7E;

  logic        clk = 1'b0, rst_n = 1'b0, bit_en = 1'b0, bit_in = 1'b0, len_chk_en = 1'b0;
  logic [15:0] max_len = '0;
  logic        out_valid, out_sof, out_eof, st_good, st_abort, st_too_long, st_misalign;
  logic [7:0]  out_data;

  hdlc_rx_limit #(.LEN_W(16)) i_hdlc_rx_limit (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
    .len_chk_en(len_chk_en), .max_len(max_len),
    .out_valid(out_valid), .out_data(out_data), .out_sof(out_sof), .out_eof(out_eof),
    .st_good(st_good), .st_abort(st_abort), .st_too_long(st_too_long), .st_misalign(st_misalign));

  always #4 clk = ~clk;

  int checks = 0, fails = 0, gap = 0, tx_ones = 0;
  logic [7:0] rx_data [0:511];
  logic       rx_sof  [0:511];
  int         rx_n = 0, eof_n = 0, sof_n = 0;
  logic [3:0] eof_st = '0;
  logic       eof_v = 1'b0;

  always @(negedge clk) if (rst_n) begin
    if (out_valid) begin
      if (rx_n < 512) begin rx_data[rx_n] = out_data; rx_sof[rx_n] = out_sof; end
      rx_n++;
    end
    if (out_sof) sof_n++;
    if (out_eof) begin
      eof_n++;
      eof_st = {st_good, st_abort, st_too_long, st_misalign};
      eof_v  = out_valid;
    end
  end

  function automatic logic [7:0] pat(int seed, int i);
    case (seed)
      0: return 8'(i * 29 + 7);
      1: return 8'hFF;
      2: return 8'h7E;
      3: return (i % 2 != 0) ? 8'h3F : 8'hFC;
      default: return 8'(i * 53 + seed * 17) ^ 8'hA5;
    endcase
  endfunction

  task automatic chk(string tag, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic send_bit(logic b);
    @(negedge clk); bit_in = b; bit_en = 1'b1;
    @(negedge clk); bit_en = 1'b0; bit_in = ~b;
    repeat (gap) @(negedge clk);
  endtask

  task automatic send_flag();
    for (int k = 0; k < 8; k++) send_bit(FLAG[k]);
    tx_ones = 0;
  endtask

  task automatic send_dbit(logic b);
    send_bit(b);
    if (b) begin
      tx_ones++;
      if (tx_ones == 5) begin send_bit(1'b0); tx_ones = 0; end
    end else tx_ones = 0;
  endtask

  task automatic send_byte(logic [7:0] d);
    for (int k = 0; k < 8; k++) send_dbit(d[k]);
  endtask

  task automatic send_frame(int seed, int n);
    send_flag();
    for (int i = 0; i < n; i++) send_byte(pat(seed, i));
    send_flag();
  endtask

  task automatic clr();
    rx_n = 0; eof_n = 0; sof_n = 0; eof_st = '0; eof_v = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic do_reset(logic en, int m);
    @(negedge clk); rst_n = 1'b0; len_chk_en = en; max_len = 16'(m);
    repeat (3) @(negedge clk);
    rst_n = 1'b1; tx_ones = 0;
    clr();
  endtask

  task automatic check_frame(string tag, int seed, int exp_n, logic [3:0] exp_st, logic exp_v);
    chk(tag, rx_n, exp_n, "octets delivered");
    for (int i = 0; i < exp_n && i < rx_n; i++)
      chk(tag, int'(rx_data[i]), int'(pat(seed, i)), $sformatf("octet %0d", i));
    chk(tag, sof_n, (exp_n > 0) ? 1 : 0, "sof count");
    if (exp_n > 0 && rx_n > 0) chk(tag, int'(rx_sof[0]), 1, "sof on first octet");
    chk(tag, eof_n, 1, "eof count");
    chk({tag, " R11"}, int'(eof_st), int'(exp_st), "status {good,abort,long,misalign}");
    chk(tag, int'(eof_v), int'(exp_v), "valid with eof");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R10 watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    do_reset(1'b0, 0);
    @(negedge clk);
    chk("R1", int'({out_valid, out_sof, out_eof, st_good, st_abort, st_too_long, st_misalign}), 0, "outputs after reset");
    chk("R1", int'(out_data), 0, "data after reset");
    send_byte(8'h55); send_byte(8'hA3); send_byte(8'h00); send_byte(8'hC9);
    settle();
    chk("R1", rx_n + eof_n, 0, "output before first flag");

    for (int seed = 0; seed < 6; seed++)
      for (int n = 1; n <= 6; n++) begin
        gap = (seed + n) % 3;
        clr();
        send_frame(seed, n);
        settle();
        check_frame((seed >= 1 && seed <= 3) ? "R3" : ((gap != 0) ? "R10" : "R2"), seed, n, 4'b1000, 1'b1);
      end
    gap = 0;

    clr();
    repeat (6) send_flag();
    settle();
    chk("R4", rx_n + eof_n + sof_n, 0, "outputs for back-to-back flags");

    do_reset(1'b0, 3);
    send_frame(4, 40);
    settle();
    check_frame("R7", 4, 40, 4'b1000, 1'b1);

    for (int m = 0; m <= 5; m++) begin
      do_reset(1'b1, m);
      for (int n = 1; n <= 7; n++) begin
        clr();
        send_frame(4 + n, n);
        settle();
        if (n <= m) check_frame("R8", 4 + n, n, 4'b1000, 1'b1);
        else        check_frame("R6", 4 + n, m, 4'b0010, m > 0);
      end
    end

    do_reset(1'b0, 0);
    send_flag();
    repeat (8) send_bit(1'b1);
    tx_ones = 0;
    settle();
    chk("R5", rx_n + eof_n, 0, "abort with no octet");
    clr();
    send_flag();
    for (int i = 0; i < 3; i++) send_byte(pat(0, i));
    repeat (8) send_bit(1'b1);
    tx_ones = 0;
    send_byte(8'h00); send_byte(8'h5A);
    settle();
    check_frame("R5", 0, 2, 4'b0100, 1'b0);
    clr();
    send_frame(3, 4);
    settle();
    check_frame("R5", 3, 4, 4'b1000, 1'b1);

    for (int k = 1; k <= 7; k++) begin
      do_reset(1'b0, 0);
      send_flag();
      send_byte(pat(0, 0)); send_byte(pat(0, 1));
      for (int j = 0; j < k; j++) send_dbit(1'b0);
      send_flag();
      settle();
      check_frame("R9", 0, (k >= 2) ? 2 : 1, 4'b0001, 1'b0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule